// File: doc/BRIEF.md
# Half-Duplex Serial Transmitter with Driver-Enable Sequencing

This block sends characters on an asynchronous serial line. It also drives the enable input of an external bus driver, which can be a tristate buffer or a differential transceiver. Characters enter a small queue through a one-cycle write strobe. An external tick marks every bit period. The block builds each frame from the queue: a low start bit, eight data bits sent least-significant first, an optional ninth bit, and a high stop bit.

The driver enable comes from the sequencer's own state and not from software. When the enable function is switched on, the enable pin goes active one full bit period before the first start bit. It stays active for one full bit period after the last stop bit. A character queued while the previous one is still shifting, or during the trailing guard period, follows on without a gap in the enable. The pin polarity is selectable.

Software sees three status outputs: a queue-has-room flag, a transmission-complete flag and the queue fill level. Each of the two flags has an interrupt enable, and both feed one interrupt output. The complete flag sets only when the queue is empty and the stop bit has fully left the line. Any write request clears it.

Top module: `uart_de_tx`

## Requirements
- R1: With the line idle, `tx_o` is 1. A frame is a start bit of 0, then `wr_data` bits 0 to 7 in that order, then a stop bit of 1. Each bit lasts exactly one period between consecutive `baud_tick` pulses.
- R2: When `cfg_nine` is 1 at the write, the character carries a ninth bit equal to the `wr_bit8` value captured with that same write. This bit is sent between data bit 7 and the stop bit.
- R3: With `cfg_de_on` = 1, the driver enable becomes active for exactly one bit period before the start bit of a character sent from idle, and `tx_o` stays 1 during that period.
- R4: With `cfg_de_on` = 1, the enable stays active for one bit period after the stop bit and then goes inactive. With `cfg_de_on` = 0 the enable is never active, and there are no lead or trail periods.
- R5: A character written during the stop bit of the previous character, or during the trailing guard period, starts at the very next bit boundary. It has no lead period, and the enable stays active without a break.
- R6: `de_o` equals the enable activity XOR `cfg_de_inv`, so with `cfg_de_inv` = 1 the pin is low while active and high while inactive.
- R7: `room_o` is 1 exactly when the queue holds fewer than DEPTH entries, whatever the shifter is doing.
- R8: `done_o` is 1 after reset. It sets at the end of a stop bit only if the queue is empty at that point, and it is 0 while any character is queued or shifting.
- R9: A cycle with `wr_en` = 1 makes `done_o` read 0 on the next cycle, even if a frame ends in that same cycle.
- R10: The queue holds DEPTH entries and `level_o` gives its fill count. A write while the queue is full is dropped.
- R11: `irq_o` = (`room_o` AND `ie_room`) OR (`done_o` AND `ie_done`).
- R12: `tx_o` changes only on the clock edge that consumes a `baud_tick` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| wr_en | input | 1 | Write strobe for one character |
| wr_data | input | 8 | Character data bits |
| wr_bit8 | input | 1 | Ninth data bit, captured with the write |
| cfg_nine | input | 1 | 1 selects 9-bit characters, captured with the write |
| cfg_de_on | input | 1 | Enables driver-enable sequencing |
| cfg_de_inv | input | 1 | 1 makes the enable pin active-low |
| ie_room | input | 1 | Interrupt enable for the room flag |
| ie_done | input | 1 | Interrupt enable for the complete flag |
| tx_o | output | 1 | Serial line |
| de_o | output | 1 | Driver enable pin |
| room_o | output | 1 | Queue can take another character |
| done_o | output | 1 | Transmission complete |
| level_o | output | $clog2(DEPTH+1) | Queue fill count |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with DEPTH = 4, so four back-to-back writes fill the queue and a fifth write tests the drop rule within a few cycles. It drives `baud_tick` once every four clocks, which keeps each frame short enough to record every bit period of many frames. At the same time, writes can still land within one chosen bit period, such as the stop bit or the trailing guard. This makes the late-write hand-over and the completion-flag race directly observable.

// File: rtl/uart_de_tx_pkg.sv
package uart_de_tx_pkg;

    // Width of one serial character payload
    localparam int CHAR_W  = 8;
    // Shift image: stop, ninth/filler, data, start
    localparam int FRAME_W = CHAR_W + 3;
    // Bit counter must hold FRAME_W
    localparam int LEFT_W  = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_LEAD,
        SEQ_SHIFT,
        SEQ_TRAIL
    } seq_state_e;

    // One queued character, with its format latched at write time
    typedef struct packed {
        logic              nine;
        logic              bit8;
        logic [CHAR_W-1:0] data;
    } char_t;

endpackage

// File: rtl/uart_de_tx_fifo.sv
module uart_de_tx_fifo
    import uart_de_tx_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  char_t            push_data,
    input  logic             pop,
    output char_t            head,
    output logic [CNT_W-1:0] level
);

    typedef struct packed {
        char_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]  wp;
        logic [PTR_W-1:0]  rp;
        logic [CNT_W-1:0]  cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic push_ok, pop_ok;

    always_comb begin
        d       = q;
        push_ok = push && (q.cnt < CNT_W'(DEPTH));
        pop_ok  = pop && (q.cnt != '0);
        if (push_ok) begin
            d.mem[q.wp] = push_data;
            d.wp = (q.wp == PTR_W'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        end
        if (pop_ok) begin
            d.rp = (q.rp == PTR_W'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        end
        case ({push_ok, pop_ok})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.wp  <= '0;
            q.rp  <= '0;
            q.cnt <= '0;
            q.mem <= q.mem;
        end else begin
            q <= d;
        end
    end

    assign head  = q.mem[q.rp];
    assign level = q.cnt;

endmodule

// File: rtl/uart_de_tx_seq.sv
module uart_de_tx_seq
    import uart_de_tx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  baud_tick,
    input  logic  de_on,
    input  logic  avail,
    input  char_t head,
    output logic  pop,
    output logic  frame_end,
    output logic  tx,
    output logic  de_act
);

    typedef struct packed {
        seq_state_e         st;
        logic [FRAME_W-1:0] sh;
        logic [LEFT_W-1:0]  left;
    } seq_st_t;

    seq_st_t q, d;
    logic    load;

    always_comb begin
        d         = q;
        load      = 1'b0;
        frame_end = 1'b0;
        case (q.st)
            SEQ_IDLE: begin
                if (baud_tick && avail) begin
                    if (de_on) d.st = SEQ_LEAD;
                    else       load = 1'b1;
                end
            end
            SEQ_LEAD: begin
                if (baud_tick) begin
                    if (avail) load = 1'b1;
                    else       d.st = SEQ_IDLE;
                end
            end
            SEQ_SHIFT: begin
                if (baud_tick) begin
                    if (q.left == LEFT_W'(1)) begin
                        frame_end = 1'b1;
                        if (avail)      load = 1'b1;
                        else if (de_on) d.st = SEQ_TRAIL;
                        else            d.st = SEQ_IDLE;
                    end else begin
                        d.sh   = {1'b1, q.sh[FRAME_W-1:1]};
                        d.left = q.left - 1'b1;
                    end
                end
            end
            SEQ_TRAIL: begin
                if (baud_tick) begin
                    if (avail) load = 1'b1;
                    else       d.st = SEQ_IDLE;
                end
            end
            default: d.st = SEQ_IDLE;
        endcase
        if (load) begin
            d.st   = SEQ_SHIFT;
            d.sh   = {1'b1, (head.nine ? head.bit8 : 1'b1), head.data, 1'b0};
            d.left = head.nine ? LEFT_W'(CHAR_W + 3) : LEFT_W'(CHAR_W + 2);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= SEQ_IDLE;
            q.sh   <= '1;
            q.left <= '0;
        end else begin
            q <= d;
        end
    end

    assign pop    = load;
    assign tx     = (q.st == SEQ_SHIFT) ? q.sh[0] : 1'b1;
    assign de_act = de_on && (q.st != SEQ_IDLE);

endmodule

// File: rtl/uart_de_tx_status.sv
module uart_de_tx_status #(
    parameter  int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic             frame_end,
    input  logic [CNT_W-1:0] level,
    input  logic             ie_room,
    input  logic             ie_done,
    output logic             room,
    output logic             done,
    output logic             irq
);

    typedef struct packed {
        logic done;
    } stat_st_t;

    stat_st_t q, d;

    always_comb begin
        d = q;
        if (wr_req)                           d.done = 1'b0;
        else if (frame_end && level == '0)    d.done = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q.done <= 1'b1;
        else        q      <= d;
    end

    assign room = (level < CNT_W'(DEPTH));
    assign done = q.done;
    assign irq  = (room && ie_room) || (q.done && ie_done);

endmodule

// File: rtl/uart_de_tx.sv
module uart_de_tx
    import uart_de_tx_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             wr_bit8,
    input  logic             cfg_nine,
    input  logic             cfg_de_on,
    input  logic             cfg_de_inv,
    input  logic             ie_room,
    input  logic             ie_done,
    output logic             tx_o,
    output logic             de_o,
    output logic             room_o,
    output logic             done_o,
    output logic [CNT_W-1:0] level_o,
    output logic             irq_o
);

    char_t            wr_char, head;
    logic [CNT_W-1:0] level;
    logic             pop, frame_end, de_act;

    assign wr_char = '{nine: cfg_nine, bit8: wr_bit8, data: wr_data};

    uart_de_tx_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .push_data (wr_char),
        .pop       (pop),
        .head      (head),
        .level     (level)
    );

    uart_de_tx_seq seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .de_on     (cfg_de_on),
        .avail     (level != '0),
        .head      (head),
        .pop       (pop),
        .frame_end (frame_end),
        .tx        (tx_o),
        .de_act    (de_act)
    );

    uart_de_tx_status #(.DEPTH(DEPTH)) stat_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (wr_en),
        .frame_end (frame_end),
        .level     (level),
        .ie_room   (ie_room),
        .ie_done   (ie_done),
        .room      (room_o),
        .done      (done_o),
        .irq       (irq_o)
    );

    assign de_o    = de_act ^ cfg_de_inv;
    assign level_o = level;

endmodule

// File: rtl/uart_de_tx_chk.sv
module uart_de_tx_chk #(
    parameter  int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             baud_tick,
    input logic             wr_en,
    input logic             cfg_de_inv,
    input logic             tx_o,
    input logic             de_o,
    input logic             room_o,
    input logic             done_o,
    input logic [CNT_W-1:0] level_o
);

    logic de_live;
    assign de_live = de_o ^ cfg_de_inv;

    // R12
    tx_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(baud_tick) |-> $stable(tx_o));

    // R8
    done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (level_o == '0));

    // R9
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !done_o);

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !room_o) |=> (level_o <= $past(level_o)));

    // R4
    de_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(de_live) |-> done_o);

    // R3
    de_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(de_live) |-> tx_o);

endmodule

bind uart_de_tx uart_de_tx_chk #(.DEPTH(DEPTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .wr_en      (wr_en),
    .cfg_de_inv (cfg_de_inv),
    .tx_o       (tx_o),
    .de_o       (de_o),
    .room_o     (room_o),
    .done_o     (done_o),
    .level_o    (level_o)
);

// File: tb/uart_de_tx_test.sv
module uart_de_tx_test;

    localparam int CLK   = 10;
    localparam int DEPTH = 4;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int DIV   = 4;
    localparam int LOGN  = 1024;

    // vector fields: {inv, on, nine, bit8, data}
    localparam logic [11:0] VEC [6] = '{
        {1'b0, 1'b1, 1'b0, 1'b0, 8'hA5},
        {1'b0, 1'b1, 1'b1, 1'b1, 8'h3C},
        {1'b0, 1'b1, 1'b1, 1'b0, 8'hFF},
        {1'b1, 1'b1, 1'b0, 1'b0, 8'h81},
        {1'b0, 1'b0, 1'b0, 1'b0, 8'h5A},
        {1'b1, 1'b0, 1'b1, 1'b1, 8'h00}
    };

    logic clk = 0, rst_n = 0, baud_tick = 0, wr_en = 0;
    logic [7:0] wr_data = 0;
    logic wr_bit8 = 0, cfg_nine = 0, cfg_de_on = 0, cfg_de_inv = 0;
    logic ie_room = 0, ie_done = 0;
    logic tx_o, de_o, room_o, done_o, irq_o;
    logic [CNT_W-1:0] level_o;

    int checks = 0, fails = 0;
    int nlog = 0, tdiv = 0;
    logic [2:0] lg [LOGN];

    uart_de_tx #(.DEPTH(DEPTH)) uut (.*);

    always #(CLK/2) clk = ~clk;

    // tick generator and per-bit-period recorder {done, de, tx}
    always @(negedge clk) begin
        if (baud_tick) begin
            if (nlog < LOGN) lg[nlog] = {done_o, de_o, tx_o};
            nlog = nlog + 1;
        end
        tdiv = (tdiv + 1) % DIV;
        baud_tick = (tdiv == 0);
    end

    initial begin
        #(CLK * 50000);
        fails = fails + 1;
        checks = checks + 1;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] expect_at(input logic [11:0] v, input int k);
        logic inv, on, nine, b8, tx, act, dn;
        logic [7:0] d;
        int s, nb, j;
        {inv, on, nine, b8, d} = v;
        s  = on ? 1 : 0;
        nb = nine ? 11 : 10;
        tx = 1'b1;
        if (k >= s && k < s + nb) begin
            j = k - s;
            if (j == 0)              tx = 1'b0;
            else if (j <= 8)         tx = d[j-1];
            else if (nine && j == 9) tx = b8;
        end
        act = on && (k < nb + 2 * s);
        dn  = (k >= s + nb);
        return {dn, act ^ inv, tx};
    endfunction

    task automatic wait_log(input int n);
        do begin
            @(negedge clk);
            #1;
        end while (nlog < n);
    endtask

    task automatic put(input logic [7:0] d, input logic b8, input logic nine);
        wr_data = d; wr_bit8 = b8; cfg_nine = nine; wr_en = 1;
        @(negedge clk); #1;
        wr_en = 0;
    endtask

    int base, bad, badk;
    logic [2:0] e;
    logic [11:0] va, vb;

    initial begin
        // reset state
        repeat (3) @(negedge clk);
        #1;
        rst_n = 1;
        @(negedge clk); #1;
        chk(tx_o == 1, "R1 idle line", tx_o, 1);
        chk(de_o == 0, "R4 enable inactive at reset", de_o, 0);
        chk(done_o == 1, "R8 complete at reset", done_o, 1);
        chk(room_o == 1 && level_o == 0, "R10 empty at reset", {room_o, level_o}, {1'b1, 3'd0});
        chk(irq_o == 0, "R11 irq masked", irq_o, 0);
        ie_done = 1; #1;
        chk(irq_o == 1, "R11 irq from done", irq_o, 1);
        ie_done = 0; ie_room = 1; #1;
        chk(irq_o == 1, "R11 irq from room", irq_o, 1);
        ie_room = 0; #1;

        // table of single-character frames (R1 R2 R3 R4 R6 R9)
        foreach (VEC[i]) begin
            cfg_de_inv = VEC[i][11];
            cfg_de_on  = VEC[i][10];
            wait_log(nlog + 2);
            base = nlog;
            put(VEC[i][7:0], VEC[i][8], VEC[i][9]);
            chk(done_o == 0, "R9 write clears complete", done_o, 0);
            wait_log(base + 15);
            bad = 0; badk = 0;
            for (int k = 0; k < 15; k++) begin
                e = expect_at(VEC[i], k);
                if (lg[base + k] !== e && bad == 0) begin bad = 1; badk = k; end
            end
            e = expect_at(VEC[i], badk);
            chk(bad == 0, $sformatf("R1 R2 R3 R4 R6 frame vec%0d period%0d", i, badk),
                lg[base + badk], e);
        end

        // flags while the only character is shifting (R7 R8)
        cfg_de_inv = 0; cfg_de_on = 1;
        wait_log(nlog + 2);
        base = nlog;
        put(8'h12, 0, 0);
        wait_log(base + 2);
        chk(level_o == 0 && room_o == 1, "R7 room while shifting", {room_o, level_o}, {1'b1, 3'd0});
        chk(done_o == 0, "R8 not complete while shifting", done_o, 0);
        wait_log(base + 12);
        chk(done_o == 1, "R8 complete after stop", done_o, 1);

        // late write during stop bit (R5)
        va = {1'b0, 1'b1, 1'b0, 1'b0, 8'h55};
        vb = {1'b0, 1'b1, 1'b0, 1'b0, 8'h0F};
        wait_log(nlog + 2);
        base = nlog;
        put(8'h55, 0, 0);
        wait_log(base + 11);
        put(8'h0F, 0, 0);
        wait_log(base + 24);
        bad = 0; badk = 0;
        for (int k = 0; k < 23; k++) begin
            e = (k < 11) ? expect_at(va, k) : expect_at(vb, k - 10);
            if (lg[base + k] !== e && bad == 0) begin bad = 1; badk = k; end
        end
        chk(bad == 0, $sformatf("R5 write in stop bit period%0d", badk), lg[base + badk], 0);

        // late write during trailing guard (R5)
        wait_log(nlog + 2);
        base = nlog;
        put(8'h55, 0, 0);
        wait_log(base + 12);
        put(8'h0F, 0, 0);
        wait_log(base + 26);
        bad = 0; badk = 0;
        for (int k = 0; k < 25; k++) begin
            e = (k < 12) ? expect_at(va, k) : expect_at(vb, k - 11);
            if (lg[base + k] !== e && bad == 0) begin bad = 1; badk = k; end
        end
        chk(bad == 0, $sformatf("R5 write in guard period%0d", badk), lg[base + badk], 0);

        // fill the queue, fifth write dropped (R7 R10 R11)
        wait_log(nlog + 2);
        base = nlog;
        for (int n = 0; n < 5; n++) begin
            wr_data = 8'(8'h30 + n); wr_bit8 = 0; cfg_nine = 0; wr_en = 1;
            @(negedge clk); #1;
        end
        wr_en = 0;
        chk(level_o == 3'(DEPTH), "R10 level at full", level_o, DEPTH);
        chk(room_o == 0, "R7 no room when full", room_o, 0);
        ie_room = 1; ie_done = 1; #1;
        chk(irq_o == 0, "R11 irq quiet when full and busy", irq_o, 0);
        ie_room = 0; ie_done = 0;
        wait_log(base + 60);
        bad = 0;
        for (int k = 0; k < 60; k++) if (lg[base + k][1]) bad = bad + 1;
        chk(bad == 42, "R10 only four frames sent", bad, 42);
        chk(done_o == 1 && level_o == 0, "R8 complete after queue drains", {done_o, level_o}, {1'b1, 3'd0});

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule